// File: doc/BRIEF.md
# Four-State Trellis Sequence Equalizer for a Binary Link with Two-Symbol ISI

This block recovers binary symbols from a stream of quantized receiver samples when each sample holds the current symbol plus echoes of the two previous symbols. Channel memory is two symbols, so the trellis has four states. A state holds the two most recent decisions. Each accepted sample produces eight branch metrics, one for every combination of current and past symbols. The metric is the squared difference between the received sample and the noiseless level that combination would produce, built from two programmable echo taps.

An add-compare-select stage keeps one survivor per state and records which predecessor won. The decisions are stored for a fixed window of accepted samples. When the window fills, the state with the smallest accumulated distance is traced back through the stored decisions. The window's bits then leave in the order they were sent, one per clock, with a strobe. After each window the accumulated distances are rebased on their minimum so that they stay bounded over an unlimited stream.

Samples and taps share one signed fixed-point scale. At default parameters a symbol of unit amplitude equals 64 sample counts (six fractional bits). The decoder assumes the link starts from two zero symbols, so the receiver must be reset at the start of a stream.

Top module: `isi_vit_eq`

## Requirements
- R1: After reset `dec_valid` is 0, and it stays 0 until a full window of WIN accepted samples (default 25) has been taken in.
- R2: A bit value of 1 counts as +1 and a bit value of 0 counts as -1. The noiseless level of a branch is UNIT*b(k) + tap1*b(k-1) + tap2*b(k-2), where UNIT = 2^FRAC (64 by default) and the taps are two's complement values on the same scale.
- R3: The branch distance is (sample - level)^2. Each state keeps the incoming path with the smaller sum. When the two sums are equal, the path whose oldest symbol b(k-2) is 0 wins. At window end, a tie between states goes to the lowest state number, where state = {b(k-1), b(k-2)}.
- R4: The trellis begins in state 00. The two symbols before the first sample are taken as 0.
- R5: If the last sample of a window is taken at clock edge X, the window's WIN bits come out on edges X+1 to X+WIN. They appear as `dec_valid`=1 on consecutive cycles, first-sent bit first, with `dec_valid` low again after edge X+WIN+1 unless another window is ready.
- R6: A cycle with `smp_valid`=0 changes nothing: not the distances, not the window position, and not the decoded bits, whatever `smp_data` holds.
- R7: After each window, every accumulated distance has the minimum subtracted. No accumulated distance ever reaches half its range, over any length of stream.
- R8: With noise well inside the decision margin and |tap1|+|tap2| below 0.9 UNIT, the decoded bit stream equals the transmitted stream across many windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; the sample is taken when high |
| smp_data | input | SMP_W (8) | Signed received sample |
| tap1 | input | TAP_W (8) | Signed echo weight of b(k-1) |
| tap2 | input | TAP_W (8) | Signed echo weight of b(k-2) |
| dec_valid | output | 1 | High while a decoded bit is presented |
| dec_bit | output | 1 | Decoded bit, first-sent first |

## Verification
The bench covers the following corner cases and the failure each one exposes:
- **All-zero samples with zero taps.** Every branch ties. A design that breaks ties toward the other predecessor or the other end state puts out ones instead of zeros.
- **Window timing.** One isolated window is timed edge by edge. A misplaced traceback register or a wrong output counter shows up as a strobe that is early, late, or the wrong length.
- **Idle cycles.** Stretches of `smp_valid` low carry garbage `smp_data`. A design that lets idle cycles update distances or advance the window position mis-decodes or releases bits early.
- **Taps and noise.** Negative, documented and random taps, with small noise, run over forty windows. This catches wrong level signs, a wrong start state and wrong traceback ordering.

// File: rtl/isi_vit_pkg.sv
`timescale 1ns/1ps
package isi_vit_pkg;
    localparam int NUM_ST = 4;   // trellis states
    localparam int NUM_BR = 8;   // branches: {b(k), b(k-1), b(k-2)}

    typedef logic [1:0] st_t;    // {b(k-1), b(k-2)}

    // Branch index for entering state nxt from the predecessor whose oldest bit is old_lsb
    function automatic logic [2:0] br_idx(input st_t nxt, input logic old_lsb);
        return {nxt, old_lsb};
    endfunction

    // Predecessor of nxt whose b(k-2) equals old_lsb
    function automatic st_t pred_of(input st_t nxt, input logic old_lsb);
        return {nxt[0], old_lsb};
    endfunction
endpackage

// File: rtl/isi_vit_bmu.sv
`timescale 1ns/1ps
module isi_vit_bmu
    import isi_vit_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int TAP_W = 8,
    parameter int FRAC  = 6,
    parameter int LVL_W = TAP_W + 3,
    parameter int ERR_W = ((SMP_W > LVL_W) ? SMP_W : LVL_W) + 1,
    parameter int BM_W  = 2 * ERR_W
) (
    input  logic signed [SMP_W-1:0]        smp,
    input  logic signed [TAP_W-1:0]        h1,
    input  logic signed [TAP_W-1:0]        h2,
    output logic [NUM_BR-1:0][BM_W-1:0]    bm
);
    localparam logic signed [LVL_W-1:0] UNIT = LVL_W'(1 << FRAC);

    logic signed [LVL_W-1:0] h1_x, h2_x;
    assign h1_x = LVL_W'(h1);
    assign h2_x = LVL_W'(h2);

    // One squared-error distance per hypothesis of {b(k), b(k-1), b(k-2)}
    always_comb begin
        for (int i = 0; i < NUM_BR; i++) begin
            logic [2:0]               bi;
            logic signed [LVL_W-1:0]  lvl;
            logic signed [ERR_W-1:0]  err;
            logic signed [BM_W-1:0]   err_x;
            logic signed [BM_W-1:0]   sq;
            bi    = 3'(i);
            lvl   = (bi[2] ? UNIT : -UNIT)
                  + (bi[1] ? h1_x : -h1_x)
                  + (bi[0] ? h2_x : -h2_x);
            err   = ERR_W'(smp) - ERR_W'(lvl);
            err_x = BM_W'(err);
            sq    = err_x * err_x;
            bm[i] = $unsigned(sq);
        end
    end
endmodule

// File: rtl/isi_vit_acs.sv
`timescale 1ns/1ps
module isi_vit_acs
    import isi_vit_pkg::*;
#(
    parameter int BM_W = 24,
    parameter int MW   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          renorm,
    input  logic [NUM_BR-1:0][BM_W-1:0]   bm,
    output logic [NUM_ST-1:0]             dec,
    output st_t                           best
);
    localparam logic [MW-1:0] INIT_BIG = MW'(1) << (MW - 2);

    typedef struct packed {
        logic [NUM_ST-1:0][MW-1:0] pm;
    } acs_st_t;

    acs_st_t q, d;
    logic [MW-1:0]             mn;
    logic [NUM_ST-1:0][MW-1:0] base;
    logic [NUM_ST-1:0][MW-1:0] surv;

    always_comb begin
        // smallest accumulated distance, lowest state on a tie
        mn   = q.pm[0];
        best = '0;
        for (int s = 1; s < NUM_ST; s++) begin
            if (q.pm[s] < mn) begin
                mn   = q.pm[s];
                best = st_t'(s);
            end
        end
        // rebase after a window has been released
        for (int s = 0; s < NUM_ST; s++) begin
            base[s] = renorm ? (q.pm[s] - mn) : q.pm[s];
        end
        // add-compare-select; a tie keeps the predecessor with b(k-2)=0
        for (int n = 0; n < NUM_ST; n++) begin
            logic [MW-1:0] c0, c1;
            c0 = base[pred_of(st_t'(n), 1'b0)] + MW'(bm[br_idx(st_t'(n), 1'b0)]);
            c1 = base[pred_of(st_t'(n), 1'b1)] + MW'(bm[br_idx(st_t'(n), 1'b1)]);
            dec[n]  = (c1 < c0);
            surv[n] = (c1 < c0) ? c1 : c0;
        end
        d    = q;
        d.pm = in_valid ? surv : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pm[0] <= '0;
            for (int s = 1; s < NUM_ST; s++) q.pm[s] <= INIT_BIG;
        end else begin
            q <= d;
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.pm[0][MW-1] | q.pm[1][MW-1] | q.pm[2][MW-1] | q.pm[3][MW-1]));

    // R7
    renorm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (renorm && !in_valid) |=> (mn == '0));

    // R3
    min_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !renorm) |=> (mn >= $past(mn)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !renorm) |=> $stable(q.pm));
endmodule

// File: rtl/isi_vit_tbu.sv
`timescale 1ns/1ps
module isi_vit_tbu
    import isi_vit_pkg::*;
#(
    parameter int WIN = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NUM_ST-1:0] dec,
    input  st_t               best,
    output logic              pend,
    output logic              out_valid,
    output logic              out_bit
);
    localparam int CW = $clog2(WIN + 1);

    // steps 0 and 1 of a window only decide bits of the previous window: not stored
    typedef struct packed {
        logic [CW-1:0]                   wcnt;
        logic                            pend;
        logic [WIN-1:2][NUM_ST-1:0]      mem;
        logic [WIN-1:0]                  obuf;
        logic [CW-1:0]                   ocnt;
    } tb_st_t;

    tb_st_t         q, d;
    logic [WIN-1:0] trc;

    // trace back from the best end state through the stored decisions
    always_comb begin
        logic [WIN-1:0] t;
        t          = '0;
        t[WIN-1]   = best[1];
        t[WIN-2]   = best[0];
        for (int j = WIN - 1; j >= 2; j--) begin
            t[j-2] = q.mem[j][{t[j], t[j-1]}];
        end
        trc = t;
    end

    always_comb begin
        d      = q;
        d.pend = 1'b0;
        if (in_valid) begin
            if (q.wcnt >= CW'(2)) d.mem[q.wcnt] = dec;
            if (q.wcnt == CW'(WIN - 1)) begin
                d.wcnt = '0;
                d.pend = 1'b1;
            end else begin
                d.wcnt = q.wcnt + CW'(1);
            end
        end
        if (q.pend) begin
            d.obuf = trc;
            d.ocnt = CW'(WIN);
        end else if (q.ocnt != '0) begin
            d.obuf = q.obuf >> 1;
            d.ocnt = q.ocnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend      = q.pend;
    assign out_valid = (q.ocnt != '0);
    assign out_bit   = q.obuf[0];

    // R5
    release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |=> out_valid);
endmodule

// File: rtl/isi_vit_eq.sv
`timescale 1ns/1ps
module isi_vit_eq
    import isi_vit_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int TAP_W = 8,
    parameter int FRAC  = 6,
    parameter int WIN   = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [SMP_W-1:0]  smp_data,
    input  logic signed [TAP_W-1:0]  tap1,
    input  logic signed [TAP_W-1:0]  tap2,
    output logic                     dec_valid,
    output logic                     dec_bit
);
    localparam int LVL_W = TAP_W + 3;
    localparam int ERR_W = ((SMP_W > LVL_W) ? SMP_W : LVL_W) + 1;
    localparam int BM_W  = 2 * ERR_W;
    localparam int MW    = BM_W + $clog2(WIN) + 3;

    logic [NUM_BR-1:0][BM_W-1:0] bm;
    logic [NUM_ST-1:0]           dec;
    st_t                         best;
    logic                        pend;

    isi_vit_bmu #(
        .SMP_W(SMP_W), .TAP_W(TAP_W), .FRAC(FRAC),
        .LVL_W(LVL_W), .ERR_W(ERR_W), .BM_W(BM_W)
    ) bmu_i (
        .smp (smp_data),
        .h1  (tap1),
        .h2  (tap2),
        .bm  (bm)
    );

    isi_vit_acs #(.BM_W(BM_W), .MW(MW)) acs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (smp_valid),
        .renorm   (pend),
        .bm       (bm),
        .dec      (dec),
        .best     (best)
    );

    isi_vit_tbu #(.WIN(WIN)) tbu_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .dec       (dec),
        .best      (best),
        .pend      (pend),
        .out_valid (dec_valid),
        .out_bit   (dec_bit)
    );
endmodule

// File: tb/isi_vit_eq_tb_top.sv
`timescale 1ns/1ps
module isi_vit_eq_tb_top;
    localparam int WIN  = 25;
    localparam int MAXN = 1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_data = '0;
    logic signed [7:0] tap1 = '0;
    logic signed [7:0] tap2 = '0;
    logic              dec_valid;
    logic              dec_bit;

    int n_run  = 0;
    int n_fail = 0;
    bit tx [MAXN];
    bit rx [MAXN];
    int rx_n = 0;

    always #2 clk = ~clk;

    isi_vit_eq dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .tap1(tap1), .tap2(tap2), .dec_valid(dec_valid), .dec_bit(dec_bit)
    );

    always @(negedge clk) begin
        if (!rst_n) rx_n = 0;
        else if (dec_valid) begin
            if (rx_n < MAXN) rx[rx_n] = dec_bit;
            rx_n++;
        end
    end

    function automatic int level(bit b0, bit b1, bit b2, int h1, int h2);
        return (b0 ? 64 : -64) + (b1 ? h1 : -h1) + (b2 ? h2 : -h2);
    endfunction

    function automatic int clamp8(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 random, 1 zeros, 2 alternating, 3 ones, 4 forced zero samples (all ties)
    task automatic stream(input int h1, input int h2, input int n, input int noise,
                          input int gap, input int mode, input string req);
        int bad;
        int first;
        do_reset();
        tap1 = 8'(h1); tap2 = 8'(h2);
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: tx[i] = bit'($urandom_range(1, 0));
                2: tx[i] = bit'(i % 2);
                3: tx[i] = 1'b1;
                default: tx[i] = 1'b0;
            endcase
        end
        for (int i = 0; i < n; i++) begin
            int v;
            while (gap > 0 && int'($urandom_range(99, 0)) < gap) begin
                @(negedge clk);
                smp_valid = 1'b0;
                smp_data  = 8'($urandom);
            end
            v = level(tx[i], (i > 0) ? tx[i-1] : 1'b0, (i > 1) ? tx[i-2] : 1'b0, h1, h2);
            if (noise > 0) v = v + int'($urandom_range(2 * noise, 0)) - noise;
            if (mode == 4) v = 0;
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = 8'(clamp8(v));
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (WIN + 4) @(negedge clk);
        chk(rx_n == n, req, "decoded bit count", rx_n, n);
        bad = 0; first = -1;
        for (int i = 0; i < n && i < rx_n; i++) begin
            if (rx[i] != tx[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, $sformatf("bit mismatches (first at %0d)", first), bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // R1: idle after reset
        do_reset();
        @(negedge clk);
        chk(dec_valid == 1'b0, "R1", "dec_valid after reset", int'(dec_valid), 0);

        // R1 / R6: one short of a window, then junk with smp_valid low: no output
        for (int i = 0; i < WIN - 1; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = 8'sd64;
        end
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); smp_valid = 1'b0; smp_data = 8'($urandom);
        end
        chk(rx_n == 0, "R1", "bits released before window full", rx_n, 0);

        // R5: release timing of one isolated window
        do_reset();
        tap1 = '0; tap2 = '0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = (i % 3 == 0) ? 8'sd64 : -8'sd64;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk(dec_valid == 1'b0, "R5", "dec_valid one edge after last sample", int'(dec_valid), 0);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < WIN; k++) begin
                @(negedge clk);
                if (dec_valid) hi++;
            end
            chk(hi == WIN, "R5", "consecutive strobe cycles", hi, WIN);
        end
        @(negedge clk);
        chk(dec_valid == 1'b0, "R5", "dec_valid after window drained", int'(dec_valid), 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < WIN; i++) if (rx[i] != bit'(i % 3 == 0)) bad++;
            chk(bad == 0, "R5", "first-sent bit first ordering errors", bad, 0);
        end

        // R2 / R8: zero taps, zeros pattern
        stream(0, 0, 2 * WIN, 0, 0, 1, "R2");
        // R3: all samples zero with zero taps: every branch ties, expect zeros
        stream(0, 0, 2 * WIN, 0, 0, 4, "R3");
        // R2: example taps 0.6 / 0.2 with alternating bits
        stream(38, 13, 3 * WIN, 0, 0, 2, "R2");
        // R4: strong positive taps, all ones from a zero history
        stream(38, 19, 2 * WIN, 0, 0, 3, "R4");
        // R2: negative taps, random bits
        stream(-35, -17, 4 * WIN, 0, 0, 0, "R2");
        // R8: random taps, small noise
        for (int t = 0; t < 3; t++) begin
            stream(int'($urandom_range(76, 0)) - 38, int'($urandom_range(38, 0)) - 19,
                   4 * WIN, 4, 0, 0, "R8");
        end
        // R6: idle cycles with garbage data interleaved
        stream(30, -15, 6 * WIN, 3, 40, 0, "R6");
        // R7: long stream across forty windows with rebasing
        stream(-38, 19, 40 * WIN, 4, 10, 0, "R7");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule